// File: doc/BRIEF.md
# UART Register and Interrupt Core

This block is the bus-facing control core of a simple byte UART, reached through a zero-wait-state APB slave port. It holds one transmit byte and one receive byte. It also holds a status register, a control register, an interrupt-status register, a baud divisor and a read-only identification window. It tracks full and overrun conditions for both directions. Four single-cause interrupt lines and one combined line are driven from the interrupt-status bits.

Toward the line side, the block offers the pending transmit byte with a valid/ready handshake and takes received bytes on a one-cycle strobe. The bit-level serializer, the deserializer and the baud tick generator sit outside. This block only exports the divisor and a flag that says whether the divisor may be used.

Software programs the divisor and the enables, then writes bytes to the data offset and reads received bytes from it. Interrupt causes are cleared by writing ones to the interrupt-status register.

Top module: `uart_regs_ctrl`

## Requirements
- R1: After reset, the state, control, interrupt-status, divisor and both holding bytes read as zero, `tx_valid` and all interrupt outputs are low, `pready` is 1 and `pslverr` is 0.
- R2: A control write (word offset 0x08) keeps only bits [6:0]: bit0 TX enable, bit1 RX enable, bit2 TX interrupt enable, bit3 RX interrupt enable, bit4 TX-overrun interrupt enable, bit5 RX-overrun interrupt enable, bit6 a test bit that is stored and has no other effect.
- R3: The divisor (offset 0x10) stores the low 20 bits of a write. `baud_ok` is 1 exactly when the stored divisor is at least 16.
- R4: A write to the data offset 0x00 loads the transmit byte and sets transmit-full (state bit0). If transmit-full was already set, transmit-overrun (state bit2) is set and the new byte replaces the pending one on `tx_data`.
- R5: `tx_valid` is high only while transmit-full is set and TX enable is 1.
- R6: A cycle with `tx_valid` and `tx_ready` both high clears transmit-full. On that clearing, interrupt-status bit0 is set if TX interrupt enable is 1.
- R7: A `rx_strobe` while RX enable is 0 changes nothing: the state and the receive byte keep their values.
- R8: A `rx_strobe` with RX enabled stores `rx_data` and sets receive-full (state bit1), and sets interrupt-status bit1 if RX interrupt enable is 1. A read of offset 0x00 returns the receive byte and clears receive-full.
- R9: A `rx_strobe` with RX enabled while receive-full is set also sets receive-overrun (state bit3).
- R10: If a `rx_strobe` and a data-offset read fall in the same cycle, the read returns the old byte, the new byte is stored, receive-full stays set and no overrun is flagged.
- R11: Interrupt-status (offset 0x0C) bits 2 and 3 equal state bits 2 and 3 ANDed with control bits 4 and 5. Writing ones to interrupt-status clears bits 0 and 1 and clears the matching state overrun bit through bits 2 and 3. State bits 2 and 3 are write-one-to-clear, and state bits 0 and 1 ignore writes.
- R12: `irq_tx`, `irq_rx`, `irq_txovr` and `irq_rxovr` follow interrupt-status bits 0 to 3. `irq_any` is their OR.
- R13: Reads of offsets 0xFD0 to 0xFFC, in steps of 4, return 0x04, 0x00, 0x00, 0x00, 0x21, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, and writes there are ignored. Reads of any unmapped offset return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and core clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | BUS_W | APB write data |
| prdata | output | BUS_W | APB read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| tx_data | output | BYTE_W | Pending transmit byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Line side takes the offered byte |
| rx_data | input | BYTE_W | Received byte |
| rx_strobe | input | 1 | One-cycle strobe for a received byte |
| baud_div | output | DIV_W | Stored divisor |
| baud_ok | output | 1 | Divisor is at least DIV_MIN |
| irq_tx | output | 1 | TX interrupt |
| irq_rx | output | 1 | RX interrupt |
| irq_txovr | output | 1 | TX-overrun interrupt |
| irq_rxovr | output | 1 | RX-overrun interrupt |
| irq_any | output | 1 | OR of all interrupt causes |

## Verification
A read returns data combinationally in its access cycle, so the bench samples `prdata` one nanosecond after it raises `penable`, which is before the edge that applies any side effect of the read. Every register effect of a write, a strobe or a handshake appears one edge after the cycle in which it happened. The bench drives each stimulus on a falling edge and samples only after the next falling edge. The overrun interrupt bits, `tx_valid` and the interrupt lines depend combinationally on stored state, so they are checked in the same half cycle as the register readback that explains them.

// File: rtl/uart_rc_pkg.sv
package uart_rc_pkg;

   // word offsets (byte address >> 2) within the 4 KiB window
   localparam int unsigned WORD_W      = 10;
   localparam logic [9:0]  W_DATA      = 10'h000;
   localparam logic [9:0]  W_STATE     = 10'h001;
   localparam logic [9:0]  W_CTRL      = 10'h002;
   localparam logic [9:0]  W_INT       = 10'h003;
   localparam logic [9:0]  W_BAUD      = 10'h004;
   localparam logic [9:0]  W_ID_FIRST  = 10'h3F4;
   localparam int unsigned ID_COUNT    = 12;
   localparam int unsigned CTRL_W      = 7;

   // control field layout, tx_en at bit 0
   typedef struct packed {
      logic hs_test;
      logic rxo_ie;
      logic txo_ie;
      logic rx_ie;
      logic tx_ie;
      logic rx_en;
      logic tx_en;
   } ctrl_t;

   // identification byte for a given word index in the window
   function automatic logic [7:0] id_value(input int unsigned idx);
      case (idx)
         0:       id_value = 8'h04;
         4:       id_value = 8'h21;
         5:       id_value = 8'hB8;
         6:       id_value = 8'h1B;
         8:       id_value = 8'h0D;
         9:       id_value = 8'hF0;
         10:      id_value = 8'h05;
         11:      id_value = 8'hB1;
         default: id_value = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/uart_rc_txhold.sv
module uart_rc_txhold #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rstn,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              enable,
   input  logic              ready,
   input  logic              ovr_clr,
   output logic [BYTE_W-1:0] hold_byte,
   output logic              full,
   output logic              valid,
   output logic              ovr,
   output logic              sent
);

   assign valid = full & enable;
   assign sent  = valid & ready;

   always_ff @(posedge clk or negedge rstn) begin
      if (!rstn) begin
         hold_byte <= '0;
         full      <= 1'b0;
         ovr       <= 1'b0;
      end else begin
         if (load)
            hold_byte <= load_byte;
         if (load)
            full <= 1'b1;
         else if (sent)
            full <= 1'b0;
         // a byte accepted in the same cycle is not overrun
         if (load && full && !sent)
            ovr <= 1'b1;
         else if (ovr_clr)
            ovr <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_rc_rxhold.sv
module uart_rc_rxhold #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rstn,
   input  logic              strobe,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              enable,
   input  logic              drain,
   input  logic              ovr_clr,
   output logic [BYTE_W-1:0] hold_byte,
   output logic              full,
   output logic              ovr,
   output logic              arrived
);

   assign arrived = strobe & enable;

   always_ff @(posedge clk or negedge rstn) begin
      if (!rstn) begin
         hold_byte <= '0;
         full      <= 1'b0;
         ovr       <= 1'b0;
      end else begin
         if (arrived)
            hold_byte <= in_byte;
         // arrival is ordered after a same-cycle drain
         if (arrived)
            full <= 1'b1;
         else if (drain)
            full <= 1'b0;
         if (arrived && full && !drain)
            ovr <= 1'b1;
         else if (ovr_clr)
            ovr <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_rc_idrom.sv
module uart_rc_idrom
   import uart_rc_pkg::*;
#(
   parameter int unsigned BUS_W = 32
) (
   input  logic [WORD_W-1:0] word,
   output logic              hit,
   output logic [BUS_W-1:0]  value
);

   logic [ID_COUNT-1:0] hit_v;
   logic [BUS_W-1:0]    val_v [ID_COUNT];

   for (genvar g = 0; g < ID_COUNT; g++) begin : g_id
      assign hit_v[g] = (word == W_ID_FIRST + WORD_W'(g));
      assign val_v[g] = hit_v[g] ? BUS_W'(id_value(g)) : '0;
   end

   always_comb begin
      value = '0;
      for (int i = 0; i < ID_COUNT; i++)
         value = value | val_v[i];
   end

   assign hit = |hit_v;

endmodule

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
   import uart_rc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned BUS_W   = 32,
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned DIV_W   = 20,
   parameter int unsigned DIV_MIN = 16
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [BUS_W-1:0]  pwdata,
   output logic [BUS_W-1:0]  prdata,
   output logic              pready,
   output logic              pslverr,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_strobe,
   output logic [DIV_W-1:0]  baud_div,
   output logic              baud_ok,
   output logic              irq_tx,
   output logic              irq_rx,
   output logic              irq_txovr,
   output logic              irq_rxovr,
   output logic              irq_any
);

   localparam int unsigned INT_W = 4;

   // elaboration-time parameter checks
   if (ADDR_W < 12)      $error("ADDR_W must cover the 4 KiB window");
   if (BUS_W < DIV_W)    $error("BUS_W must hold the divisor");
   if (BUS_W < BYTE_W)   $error("BUS_W must hold a byte");
   if (BUS_W < CTRL_W)   $error("BUS_W must hold the control field");
   if (DIV_MIN == 0)     $error("DIV_MIN must be nonzero");

   // ---------------- bus decode ----------------
   logic              acc, wr_acc, rd_acc, upper_zero;
   logic [WORD_W-1:0] word;

   assign acc    = psel & penable;
   assign wr_acc = acc & pwrite;
   assign rd_acc = acc & ~pwrite;
   assign word   = paddr[11:2];

   if (ADDR_W > 12) begin : g_wide_addr
      assign upper_zero = ~|paddr[ADDR_W-1:12];
   end else begin : g_exact_addr
      assign upper_zero = 1'b1;
   end

   logic sel_data, sel_state, sel_ctrl, sel_int, sel_baud;
   assign sel_data  = upper_zero & (word == W_DATA);
   assign sel_state = upper_zero & (word == W_STATE);
   assign sel_ctrl  = upper_zero & (word == W_CTRL);
   assign sel_int   = upper_zero & (word == W_INT);
   assign sel_baud  = upper_zero & (word == W_BAUD);

   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   // ---------------- control and divisor ----------------
   ctrl_t             ctrl_q;
   logic [CTRL_W-1:0] ctrl_bits;
   logic [DIV_W-1:0]  baud_q;

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         ctrl_q <= '0;
         baud_q <= '0;
      end else begin
         if (wr_acc && sel_ctrl)
            ctrl_q <= ctrl_t'(pwdata[CTRL_W-1:0]);
         if (wr_acc && sel_baud)
            baud_q <= pwdata[DIV_W-1:0];
      end
   end

   assign ctrl_bits = ctrl_q;
   assign baud_div  = baud_q;
   assign baud_ok   = (baud_q >= DIV_W'(DIV_MIN));

   // ---------------- holding registers ----------------
   logic              tx_full, tx_ovr, tx_sent, tx_ovr_clr;
   logic              rx_full, rx_ovr, rx_arrived, rx_ovr_clr, rx_drain;
   logic [BYTE_W-1:0] rx_byte;

   assign tx_ovr_clr = wr_acc & (sel_state | sel_int) & pwdata[2];
   assign rx_ovr_clr = wr_acc & (sel_state | sel_int) & pwdata[3];
   assign rx_drain   = rd_acc & sel_data;

   uart_rc_txhold #(.BYTE_W(BYTE_W)) tx_i (
      .clk       (pclk),
      .rstn      (presetn),
      .load      (wr_acc & sel_data),
      .load_byte (pwdata[BYTE_W-1:0]),
      .enable    (ctrl_q.tx_en),
      .ready     (tx_ready),
      .ovr_clr   (tx_ovr_clr),
      .hold_byte (tx_data),
      .full      (tx_full),
      .valid     (tx_valid),
      .ovr       (tx_ovr),
      .sent      (tx_sent)
   );

   uart_rc_rxhold #(.BYTE_W(BYTE_W)) rx_i (
      .clk       (pclk),
      .rstn      (presetn),
      .strobe    (rx_strobe),
      .in_byte   (rx_data),
      .enable    (ctrl_q.rx_en),
      .drain     (rx_drain),
      .ovr_clr   (rx_ovr_clr),
      .hold_byte (rx_byte),
      .full      (rx_full),
      .ovr       (rx_ovr),
      .arrived   (rx_arrived)
   );

   // ---------------- interrupt status ----------------
   logic             int_tx_q, int_rx_q;
   logic [INT_W-1:0] int_stat;
   logic [INT_W-1:0] state_bits;

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         int_tx_q <= 1'b0;
         int_rx_q <= 1'b0;
      end else begin
         if (tx_sent && ctrl_q.tx_ie)
            int_tx_q <= 1'b1;
         else if (wr_acc && sel_int && pwdata[0])
            int_tx_q <= 1'b0;
         if (rx_arrived && ctrl_q.rx_ie)
            int_rx_q <= 1'b1;
         else if (wr_acc && sel_int && pwdata[1])
            int_rx_q <= 1'b0;
      end
   end

   assign int_stat   = {rx_ovr & ctrl_q.rxo_ie, tx_ovr & ctrl_q.txo_ie,
                        int_rx_q, int_tx_q};
   assign state_bits = {rx_ovr, tx_ovr, rx_full, tx_full};

   assign irq_tx    = int_stat[0];
   assign irq_rx    = int_stat[1];
   assign irq_txovr = int_stat[2];
   assign irq_rxovr = int_stat[3];
   assign irq_any   = |int_stat;

   // ---------------- read mux ----------------
   logic             id_hit;
   logic [BUS_W-1:0] id_val;

   uart_rc_idrom #(.BUS_W(BUS_W)) id_i (
      .word  (word),
      .hit   (id_hit),
      .value (id_val)
   );

   always_comb begin
      prdata = '0;
      if (rd_acc) begin
         if (sel_data)
            prdata = BUS_W'(rx_byte);
         else if (sel_state)
            prdata = BUS_W'(state_bits);
         else if (sel_ctrl)
            prdata = BUS_W'(ctrl_bits);
         else if (sel_int)
            prdata = BUS_W'(int_stat);
         else if (sel_baud)
            prdata = BUS_W'(baud_q);
         else if (upper_zero && id_hit)
            prdata = id_val;
      end
   end

endmodule

// File: rtl/uart_regs_ctrl_chk.sv
module uart_regs_ctrl_chk #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned BUS_W   = 32,
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned DIV_W   = 20,
   parameter int unsigned DIV_MIN = 16
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [BUS_W-1:0]  pwdata,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              tx_full,
   input logic              rx_full,
   input logic              rx_strobe,
   input logic [BYTE_W-1:0] rx_byte,
   input logic [6:0]        ctrl_bits,
   input logic              baud_ok,
   input logic              irq_tx,
   input logic              irq_rx,
   input logic              irq_txovr,
   input logic              irq_rxovr,
   input logic              irq_any
);

   logic data_rd, data_wr, baud_wr;
   assign data_rd = psel & penable & ~pwrite & (paddr[ADDR_W-1:2] == '0);
   assign data_wr = psel & penable &  pwrite & (paddr[ADDR_W-1:2] == '0);
   assign baud_wr = psel & penable &  pwrite & (paddr == ADDR_W'(16));

   // R5
   tx_gate_chk: assert property (@(posedge pclk) disable iff (!presetn)
      tx_valid |-> ctrl_bits[0]);

   // R6
   tx_drain_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (tx_valid && tx_ready && !data_wr) |=> !tx_full);

   // R7
   rx_ignore_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (rx_strobe && !ctrl_bits[1]) |=> ($stable(rx_full) && $stable(rx_byte)));

   // R8
   rx_fill_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (rx_strobe && ctrl_bits[1]) |=> rx_full);

   // R8
   rx_drain_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (data_rd && !rx_strobe) |=> !rx_full);

   // R11
   txo_mask_chk: assert property (@(posedge pclk) disable iff (!presetn)
      !ctrl_bits[4] |-> !irq_txovr);

   // R11
   rxo_mask_chk: assert property (@(posedge pclk) disable iff (!presetn)
      !ctrl_bits[5] |-> !irq_rxovr);

   // R12
   irq_or_chk: assert property (@(posedge pclk) disable iff (!presetn)
      irq_any == (irq_tx | irq_rx | irq_txovr | irq_rxovr));

   // R3
   baud_low_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (baud_wr && (pwdata[DIV_W-1:0] < DIV_W'(DIV_MIN))) |=> !baud_ok);

endmodule

bind uart_regs_ctrl uart_regs_ctrl_chk #(
   .ADDR_W(ADDR_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W),
   .DIV_W(DIV_W), .DIV_MIN(DIV_MIN)
) chk_i (
   .pclk      (pclk),
   .presetn   (presetn),
   .psel      (psel),
   .penable   (penable),
   .pwrite    (pwrite),
   .paddr     (paddr),
   .pwdata    (pwdata),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_full   (tx_full),
   .rx_full   (rx_full),
   .rx_strobe (rx_strobe),
   .rx_byte   (rx_byte),
   .ctrl_bits (ctrl_bits),
   .baud_ok   (baud_ok),
   .irq_tx    (irq_tx),
   .irq_rx    (irq_rx),
   .irq_txovr (irq_txovr),
   .irq_rxovr (irq_rxovr),
   .irq_any   (irq_any)
);

// File: tb/uart_regs_ctrl_tb_top.sv
module uart_regs_ctrl_tb_top;

   localparam logic [11:0] A_DATA  = 12'h000;
   localparam logic [11:0] A_STATE = 12'h004;
   localparam logic [11:0] A_CTRL  = 12'h008;
   localparam logic [11:0] A_INT   = 12'h00C;
   localparam logic [11:0] A_BAUD  = 12'h010;
   localparam logic [11:0] A_ID    = 12'hFD0;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_strobe = 1'b0;
   logic [19:0] baud_div;
   logic        baud_ok;
   logic        irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;

   int errors = 0;
   int checks = 0;

   always #5 pclk = ~pclk;

   uart_regs_ctrl dut_i (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
      .rx_strobe(rx_strobe), .baud_div(baud_div), .baud_ok(baud_ok),
      .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txovr(irq_txovr),
      .irq_rxovr(irq_rxovr), .irq_any(irq_any)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge pclk);
      penable = 1'b1;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b0; paddr = a;
      @(negedge pclk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a,
                         input logic [31:0] exp);
      logic [31:0] v;
      apb_rd(a, v);
      chk(req, $sformatf("read 0x%03h", a), v, exp);
   endtask

   task automatic rx_push(input logic [7:0] b);
      @(negedge pclk);
      rx_strobe = 1'b1; rx_data = b;
      @(negedge pclk);
      rx_strobe = 1'b0;
   endtask

   task automatic tx_take();
      @(negedge pclk);
      tx_ready = 1'b1;
      @(negedge pclk);
      tx_ready = 1'b0;
   endtask

   task automatic irq_chk(input string req, input logic [3:0] exp);
      chk(req, "irq lines", {27'd0, irq_any, irq_rxovr, irq_txovr, irq_rx, irq_tx},
          {27'd0, |exp, exp});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge pclk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      logic [7:0]  id_exp [12];
      id_exp = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h21, 8'hB8,
                 8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

      repeat (3) @(negedge pclk);
      presetn = 1'b1;

      // R1 reset state
      rd_chk("R1", A_STATE, 0);
      rd_chk("R1", A_CTRL, 0);
      rd_chk("R1", A_INT, 0);
      rd_chk("R1", A_BAUD, 0);
      rd_chk("R1", A_DATA, 0);
      chk("R1", "tx_valid/ready/slverr", {29'd0, tx_valid, pready, pslverr}, 32'h2);
      irq_chk("R1", 4'h0);

      // R2 control width and test bit
      apb_wr(A_CTRL, 32'hFFFF_FF80);
      rd_chk("R2", A_CTRL, 0);
      apb_wr(A_CTRL, 32'hFFFF_FFFF);
      rd_chk("R2", A_CTRL, 32'h7F);
      apb_wr(A_CTRL, 32'h40);
      rd_chk("R2", A_CTRL, 32'h40);
      rd_chk("R2", A_STATE, 0);
      chk("R2", "tx_valid with test bit", {31'd0, tx_valid}, 0);
      apb_wr(A_CTRL, 0);

      // R3 divisor sweep
      for (int d = 0; d <= 40; d++) begin
         apb_wr(A_BAUD, d);
         rd_chk("R3", A_BAUD, d);
         chk("R3", "baud_ok", {31'd0, baud_ok}, {31'd0, d >= 16});
      end
      apb_wr(A_BAUD, 32'hFFF1_2345);
      rd_chk("R3", A_BAUD, 32'h12345);
      chk("R3", "baud_div port", {12'd0, baud_div}, 32'h12345);

      // R4 R5 transmit path
      apb_wr(A_CTRL, 32'h04);
      apb_wr(A_DATA, 32'h5A);
      rd_chk("R4", A_STATE, 32'h1);
      chk("R5", "tx_valid while disabled", {31'd0, tx_valid}, 0);
      apb_wr(A_CTRL, 32'h05);
      chk("R4", "tx offer", {23'd0, tx_valid, tx_data}, 32'h15A);
      apb_wr(A_DATA, 32'hA5);
      rd_chk("R4", A_STATE, 32'h5);
      chk("R4", "replaced byte", {24'd0, tx_data}, 32'hA5);
      rd_chk("R11", A_INT, 0);
      apb_wr(A_CTRL, 32'h15);
      rd_chk("R11", A_INT, 32'h4);
      irq_chk("R12", 4'h4);
      apb_wr(A_INT, 32'h4);
      rd_chk("R11", A_STATE, 32'h1);
      irq_chk("R12", 4'h0);

      // R6 line accepts
      tx_take();
      rd_chk("R6", A_STATE, 0);
      rd_chk("R6", A_INT, 32'h1);
      chk("R6", "tx_valid after accept", {31'd0, tx_valid}, 0);
      irq_chk("R12", 4'h1);
      apb_wr(A_INT, 32'h1);
      rd_chk("R11", A_INT, 0);

      // R11 state W1C, read-only full bits
      apb_wr(A_DATA, 32'h11);
      apb_wr(A_DATA, 32'h22);
      rd_chk("R4", A_STATE, 32'h5);
      apb_wr(A_STATE, 32'hF);
      rd_chk("R11", A_STATE, 32'h1);
      apb_wr(A_CTRL, 32'h01);
      tx_take();
      rd_chk("R6", A_STATE, 0);
      rd_chk("R6", A_INT, 0);

      // R7 receive disabled
      apb_wr(A_CTRL, 0);
      rx_push(8'h99);
      rd_chk("R7", A_STATE, 0);
      rd_chk("R7", A_DATA, 0);

      // R8 receive
      apb_wr(A_CTRL, 32'h0A);
      rx_push(8'h3C);
      rd_chk("R8", A_STATE, 32'h2);
      rd_chk("R8", A_INT, 32'h2);
      irq_chk("R12", 4'h2);
      rd_chk("R8", A_DATA, 32'h3C);
      rd_chk("R8", A_STATE, 0);
      apb_wr(A_INT, 32'h2);
      rd_chk("R11", A_INT, 0);

      // R9 receive overrun
      rx_push(8'h01);
      rx_push(8'h02);
      rd_chk("R9", A_STATE, 32'hA);
      rd_chk("R11", A_INT, 32'h2);
      apb_wr(A_CTRL, 32'h2A);
      rd_chk("R11", A_INT, 32'hA);
      irq_chk("R12", 4'hA);
      apb_wr(A_STATE, 32'h8);
      rd_chk("R11", A_STATE, 32'h2);
      rd_chk("R9", A_DATA, 32'h02);
      apb_wr(A_INT, 32'h2);

      // R11 sweep of overrun enables with both overruns set
      apb_wr(A_CTRL, 32'h03);
      apb_wr(A_DATA, 32'h33);
      apb_wr(A_DATA, 32'h44);
      rx_push(8'h10);
      rx_push(8'h20);
      rd_chk("R11", A_STATE, 32'hF);
      for (int e = 0; e < 4; e++) begin
         apb_wr(A_CTRL, 32'h03 | (e << 4));
         rd_chk("R11", A_INT, e << 2);
         irq_chk("R12", 4'(e << 2));
      end
      apb_wr(A_INT, 32'hC);
      rd_chk("R11", A_STATE, 32'h3);
      rd_chk("R8", A_DATA, 32'h20);
      tx_take();
      rd_chk("R6", A_STATE, 0);

      // R10 same-cycle read and arrival
      apb_wr(A_CTRL, 32'h02);
      rx_push(8'h55);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b0; paddr = A_DATA;
      @(negedge pclk);
      penable = 1'b1; rx_strobe = 1'b1; rx_data = 8'h77;
      #1 v = prdata;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; rx_strobe = 1'b0;
      chk("R10", "read returns old byte", v, 32'h55);
      rd_chk("R10", A_STATE, 32'h2);
      rd_chk("R10", A_DATA, 32'h77);
      rd_chk("R10", A_STATE, 0);

      // R13 identification window and unmapped offsets
      for (int i = 0; i < 12; i++)
         rd_chk("R13", A_ID + 12'(4 * i), {24'd0, id_exp[i]});
      apb_wr(A_ID, 32'hFF);
      rd_chk("R13", A_ID, 32'h04);
      rd_chk("R13", 12'h014, 0);
      rd_chk("R13", 12'h100, 0);
      rd_chk("R13", 12'h800, 0);
      rd_chk("R13", 12'hFCC, 0);
      apb_wr(12'h014, 32'hFF);
      rd_chk("R13", A_CTRL, 32'h02);
      rd_chk("R13", A_STATE, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule